// File: doc/BRIEF.md
# Runt-Rejecting PWM Edge Link

This block carries one logic-level PWM signal across a two-wire pulse link without ever holding a wire active for long. On the sending side, the raw input first passes through a two-flop synchroniser. A qualifier then accepts a new level only once the input has held that level for a programmable number of clock cycles. Glitches and runt pulses shorter than that time never reach the link.

Each accepted level change becomes a short marker pulse of fixed length. A rising change is marked on the set wire and a falling change on the clear wire. On the receiving side, a set/clear register rebuilds the full-width PWM from these markers. Because only edges cross the link, any pulse length can be carried.

The receiver inputs are separate ports. In normal use they are wired to the two transmit outputs, and they can also be fed from any other pair of wires. With the default parameters and a 200 MHz clock, the qualification time is 200 ns. Pulses of 100 ns or less are rejected and pulses of 350 ns or more are passed.

Top module: `pwm_edge_link`

## Requirements
- R1: After reset, `pwm_qual`, `tx_set`, `tx_clr` and `pwm_out` are all 0.
- R2: An input pulse that `pwm_in` holds for fewer than `QUAL_CYC` clock edges (e.g. 20 cycles) leaves `pwm_qual` unchanged and produces no marker on either transmit wire.
- R3: An input pulse held for 70 cycles or more is passed on. A pulse held for exactly `QUAL_CYC` edges is accepted, and one held for `QUAL_CYC-1` edges is rejected.
- R4: `pwm_qual` takes a new level exactly `QUAL_CYC+2` clock edges after `pwm_in` changes, counting from the first sampling edge. This holds for rising and falling changes alike. `pwm_qual` never changes to a level the synchronised input did not show.
- R5: A rising change of `pwm_qual` drives `tx_set` high in the same cycle for exactly `MARK_CYC` cycles, while `tx_clr` stays 0.
- R6: A falling change of `pwm_qual` drives `tx_clr` high in the same cycle for exactly `MARK_CYC` cycles, while `tx_set` stays 0.
- R7: `tx_set` and `tx_clr` are never high in the same cycle, and neither stays high longer than `MARK_CYC` cycles.
- R8: The receiver works as follows. `rx_set` alone makes `pwm_out` 1 at the next edge. `rx_clr` makes it 0 at the next edge. With neither asserted, `pwm_out` holds its level, so a pulse of any length (e.g. 2000 cycles) is rebuilt at full width.
- R9: When `rx_set` and `rx_clr` are both high, `pwm_out` becomes 0 (clear wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Raw, asynchronous PWM input |
| pwm_qual | output | 1 | Qualified PWM level on the sending side |
| tx_set | output | 1 | Marker for an accepted rising change |
| tx_clr | output | 1 | Marker for an accepted falling change |
| rx_set | input | 1 | Received set marker |
| rx_clr | input | 1 | Received clear marker |
| pwm_out | output | 1 | Rebuilt PWM level on the receiving side |

## Verification
The receiver's set and clear actions are the two functions that can fall in the same cycle. On the normal path the minimum qualified width keeps the markers apart, so the bench breaks the loopback and drives both receiver wires high together. It first raises `pwm_out` with set alone, and then asserts both wires. It judges the result by `pwm_out` being 0 one edge later. A pulse exactly at the qualification limit and one a cycle short check the boundary where an accepted change sits closest to the reject case.

// File: rtl/pwm_edge_link.sv
`timescale 1ns/1ps
module pwm_edge_link #(
  parameter int QUAL_CYC = 40,
  parameter int MARK_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic pwm_qual,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic pwm_out
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam int MW = $clog2(MARK_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] hold;
  logic [MW-1:0] set_left, clr_left;
  wire           flip = (s2 != pwm_qual) && (hold == CW'(QUAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pwm_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_qual <= 1'b0;
      hold     <= '0;
    end else if (s2 == pwm_qual || flip) begin
      hold     <= '0;
      pwm_qual <= s2;
    end else begin
      hold     <= hold + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_left <= '0;
      clr_left <= '0;
    end else begin
      if (flip && s2)            set_left <= MW'(MARK_CYC);
      else if (set_left != '0)   set_left <= set_left - 1'b1;
      if (flip && !s2)           clr_left <= MW'(MARK_CYC);
      else if (clr_left != '0)   clr_left <= clr_left - 1'b1;
    end
  end

  assign tx_set = (set_left != '0);
  assign tx_clr = (clr_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      pwm_out <= 1'b0;
    else if (rx_clr) pwm_out <= 1'b0;
    else if (rx_set) pwm_out <= 1'b1;
  end

  initial assert (QUAL_CYC > MARK_CYC && MARK_CYC > 0);

  logic [MW:0] set_run, clr_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_run <= '0;
      clr_run <= '0;
    end else begin
      set_run <= tx_set ? set_run + 1'b1 : '0;
      clr_run <= tx_clr ? clr_run + 1'b1 : '0;
      a_r7_set_len: assert (!tx_set || set_run < (MW+1)'(MARK_CYC));
      a_r7_clr_len: assert (!tx_clr || clr_run < (MW+1)'(MARK_CYC));
    end
  end

  a_r7_markers_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_set && tx_clr));
  a_r5_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_qual) |-> tx_set && !tx_clr);
  a_r6_clr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_qual) |-> tx_clr && !tx_set);
  a_r4_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_qual) |-> pwm_qual == $past(s2));
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> !pwm_out);
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set && !rx_clr |=> pwm_out);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_set && !rx_clr |=> $stable(pwm_out));
endmodule

// File: tb/pwm_edge_link_test.sv
`timescale 1ns/1ps
module pwm_edge_link_test;
  localparam int Q = 40;
  localparam int M = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0;
  logic loop = 1'b1;
  logic drv_set = 1'b0, drv_clr = 1'b0;
  logic pwm_qual, tx_set, tx_clr, pwm_out;
  wire  rx_set = loop ? tx_set : drv_set;
  wire  rx_clr = loop ? tx_clr : drv_clr;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_edge_link #(.QUAL_CYC(Q), .MARK_CYC(M)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_qual(pwm_qual),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set), .rx_clr(rx_clr),
    .pwm_out(pwm_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk(pwm_qual == 0, "R1 pwm_qual", pwm_qual, 0);
    chk(tx_set == 0 && tx_clr == 0, "R1 markers", {tx_set, tx_clr}, 0);
    chk(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
  endtask

  task automatic t_pulse(input int w, input bit expect_pass, input string req);
    int seen_q = 0, seen_m = 0;
    @(negedge clk); pwm_in = 1'b1;
    repeat (w) @(posedge clk);
    @(negedge clk); pwm_in = 1'b0;
    for (int i = 0; i < 2 * Q + 10; i++) begin
      step();
      if (pwm_qual) seen_q = 1;
      if (tx_set || tx_clr) seen_m = 1;
    end
    chk(seen_q == int'(expect_pass), {req, " qualified"}, seen_q, int'(expect_pass));
    chk(seen_m == int'(expect_pass), {req, " marker"}, seen_m, int'(expect_pass));
  endtask

  task automatic t_edge(input bit lvl);
    int hi = 0;
    @(negedge clk); pwm_in = lvl;
    repeat (Q + 1) step();
    chk(pwm_qual == !lvl, "R4 not yet", pwm_qual, !lvl);
    step();
    chk(pwm_qual == lvl, "R4 edge timing", pwm_qual, lvl);
    if (lvl) chk(tx_set && !tx_clr, "R5 set marker", {tx_set, tx_clr}, 2);
    else     chk(tx_clr && !tx_set, "R6 clr marker", {tx_set, tx_clr}, 1);
    hi = 1;
    for (int i = 0; i < M + 3; i++) begin
      step();
      if (lvl ? tx_set : tx_clr) hi++;
    end
    chk(hi == M, lvl ? "R5 marker length" : "R6 marker length", hi, M);
    chk(pwm_out == lvl, "R8 rebuilt level", pwm_out, lvl);
  endtask

  task automatic t_long();
    int lows = 0;
    @(negedge clk); pwm_in = 1'b1;
    repeat (Q + 4) step();
    for (int i = 0; i < 2000; i++) begin
      step();
      if (!pwm_out) lows++;
    end
    chk(lows == 0, "R8 long pulse held", lows, 0);
    @(negedge clk); pwm_in = 1'b0;
    repeat (Q + 4) step();
    chk(pwm_out == 0, "R8 long pulse end", pwm_out, 0);
  endtask

  task automatic t_rx();
    @(negedge clk); loop = 1'b0; drv_set = 1'b1; drv_clr = 1'b0;
    step();
    chk(pwm_out == 1, "R8 set alone", pwm_out, 1);
    @(negedge clk); drv_set = 1'b0;
    repeat (5) step();
    chk(pwm_out == 1, "R8 hold", pwm_out, 1);
    @(negedge clk); drv_set = 1'b1; drv_clr = 1'b1;
    step();
    chk(pwm_out == 0, "R9 clear wins", pwm_out, 0);
    @(negedge clk); drv_set = 1'b0; drv_clr = 1'b0; loop = 1'b1;
    step();
    chk(pwm_out == 0, "R8 hold low", pwm_out, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (2) step();
    t_reset();
    t_pulse(20, 1'b0, "R2 100ns runt");
    t_pulse(Q - 1, 1'b0, "R3 one short");
    t_pulse(Q, 1'b1, "R3 at limit");
    t_pulse(70, 1'b1, "R3 350ns pulse");
    t_edge(1'b1);
    t_edge(1'b0);
    t_long();
    t_rx();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule